// File: doc/BRIEF.md
# Two-Step Conversion Sequencer

This block is the timing controller of a subranging analog-to-digital converter that takes two passes through one flash quantizer. It accepts a start command from two active-low inputs, a chip select and a convert line. It then steps through a fixed sequence. The sample/hold goes to hold. The coarse pass settles and is strobed. The residue is formed and settles. The fine pass settles and is strobed. The corrected word is latched. After that comes an acquisition window, during which the sample/hold tracks the input again. The analog blocks are outside this design, and it only drives their control strobes.

An interrupt-request flag is high for the whole hold interval. It falls one cycle after the result latch strobe, so a reader sees new data as the flag drops. Once a cycle has started, the sequencer ignores the inputs until acquisition has ended. If convert is still low at that point, the next cycle starts without a new edge, which makes the converter free-running. Every phase length is a parameter counted in clock cycles. The acquisition length defaults to the cycle count closest to 100 ns at the given clock period.

The inputs are assumed to be synchronous to `clk`. In the requirements, "the start edge" means the clock edge at which a start is taken. H, C, R, F and A are the lengths of the hold, coarse, residue, fine and acquisition phases. L = H+C+R+F. The defaults are H=2, C=4, R=6, F=4 and A=25 (100 ns at a 4000 ps clock).

Top module: `conv_seq`

## Requirements
- R1: A start is taken when the combined request (cs_n low AND conv_n low) is sampled active after having been sampled inactive. Whichever of the two inputs falls later triggers it. A convert pulse while cs_n is high starts nothing. A request that is already active while reset is applied does not start a cycle.
- R2: After the start edge, irq and hold go high together. hold is high in exactly the cycles in which irq is high.
- R3: coarse_stb is high for one cycle, H+C cycles after the start edge. fine_stb is high for one cycle, L cycles after the start edge. At most one of the three strobes is high in any cycle.
- R4: latch_stb is high for one cycle, L+1 cycles after the start edge. irq is still high in that cycle and is low in the next.
- R5: Convert edges while irq is high, or during the A acquisition cycles, start nothing and do not change the cycle in progress.
- R6: If the request is active in the last acquisition cycle, a new cycle starts without a new edge. Successive irq rising edges are then L+1+A cycles apart.
- R7: With no start taken, irq, hold and all strobes stay low indefinitely.
- R8: Synchronous active-high rst puts the block in track mode, with irq, hold and all strobes low in the cycle after rst is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| conv_n | input | 1 | Convert command, active low |
| hold | output | 1 | Sample/hold control: 1 = hold, 0 = track |
| coarse_stb | output | 1 | Capture strobe for the coarse quantizer pass |
| fine_stb | output | 1 | Capture strobe for the fine quantizer pass |
| latch_stb | output | 1 | Strobe for the result output latch |
| irq | output | 1 | Conversion-in-progress flag; its fall marks new data |

## Verification
The main function is tried with four input patterns. A single short convert pulse under a low chip select pins down the absolute placement of each strobe and of both irq edges. A start in which convert falls first and chip select falls later shows that the later input is the trigger, and that a convert pulse with chip select high does nothing. Convert pulses that land inside a conversion and inside acquisition tell a correct lockout apart from a retrigger or an extended cycle. A convert held low across several cycles and released mid-conversion separates automatic restart at the exact period from stopping after the final acquisition.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    PH_TRACK  = 3'd0,
    PH_HOLD   = 3'd1,
    PH_COARSE = 3'd2,
    PH_RESID  = 3'd3,
    PH_FINE   = 3'd4,
    PH_LATCH  = 3'd5,
    PH_ACQ    = 3'd6
  } conv_phase_e;

  // Cycle count nearest to a time in ns for a clock period in ps
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps / 2) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // Length in cycles of a phase
  function automatic int unsigned phase_cycles(input conv_phase_e p,
                                               input int unsigned h,
                                               input int unsigned c,
                                               input int unsigned r,
                                               input int unsigned f,
                                               input int unsigned a);
    case (p)
      PH_HOLD:   return h;
      PH_COARSE: return c;
      PH_RESID:  return r;
      PH_FINE:   return f;
      PH_ACQ:    return a;
      default:   return 1;
    endcase
  endfunction

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/conv_start_detect.sv
module conv_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic conv_n,
  output logic req,
  output logic start_rise
);
  logic req_q;

  // Both active-low inputs low: whichever falls last completes the request
  assign req = ~cs_n & ~conv_n;

  // Reset to 1 so a request already active through reset needs to drop first
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b1;
    else     req_q <= req;
  end

  assign start_rise = req & ~req_q;
endmodule

// File: rtl/conv_phase_timer.sv
module conv_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned CLK_PS     = 4000,
  parameter int unsigned ACQ_NS     = 100,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned COARSE_CYC = 4,
  parameter int unsigned RESID_CYC  = 6,
  parameter int unsigned FINE_CYC   = 4,
  parameter int unsigned ACQ_CYC    = ns_to_cycles(ACQ_NS, CLK_PS)
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic conv_n,
  output logic hold,
  output logic coarse_stb,
  output logic fine_stb,
  output logic latch_stb,
  output logic irq
);
  localparam int unsigned MAX_LEN = max5(HOLD_CYC, COARSE_CYC, RESID_CYC, FINE_CYC, ACQ_CYC);
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  conv_phase_e phase, phase_nx;
  logic        req, start_rise, expired, load;
  logic [CNT_W-1:0] load_val;

  // Named internal events
  logic conv_busy;   // hold interval, irq high
  logic in_acq;      // acquisition window
  logic acq_done;    // last acquisition cycle
  logic auto_restart;

  conv_start_detect u_start (
    .clk(clk), .rst(rst), .cs_n(cs_n), .conv_n(conv_n),
    .req(req), .start_rise(start_rise)
  );

  conv_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  assign in_acq       = (phase == PH_ACQ);
  assign acq_done     = in_acq & expired;
  assign auto_restart = acq_done & req;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_TRACK:  if (start_rise) phase_nx = PH_HOLD;
      PH_HOLD:   if (expired)    phase_nx = PH_COARSE;
      PH_COARSE: if (expired)    phase_nx = PH_RESID;
      PH_RESID:  if (expired)    phase_nx = PH_FINE;
      PH_FINE:   if (expired)    phase_nx = PH_LATCH;
      PH_LATCH:                  phase_nx = PH_ACQ;
      PH_ACQ:    if (expired)    phase_nx = req ? PH_HOLD : PH_TRACK;
      default:                   phase_nx = PH_TRACK;
    endcase
  end

  assign load     = (phase_nx != phase);
  assign load_val = CNT_W'(phase_cycles(phase_nx, HOLD_CYC, COARSE_CYC,
                                        RESID_CYC, FINE_CYC, ACQ_CYC) - 1);

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_TRACK;
    else     phase <= phase_nx;
  end

  assign conv_busy  = (phase == PH_HOLD) | (phase == PH_COARSE) | (phase == PH_RESID) |
                      (phase == PH_FINE) | (phase == PH_LATCH);
  assign irq        = conv_busy;
  assign hold       = conv_busy;
  assign coarse_stb = (phase == PH_COARSE) & expired;
  assign fine_stb   = (phase == PH_FINE) & expired;
  assign latch_stb  = (phase == PH_LATCH);

  // Assertions
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq && !hold && !latch_stb); // R8
  AST_START_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRACK) && start_rise |=> irq && hold); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({coarse_stb, fine_stb, latch_stb})); // R3
  AST_LATCH_BEFORE_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(latch_stb)); // R4
  AST_ACQ_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    in_acq && !expired |=> !irq); // R5
  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (rst)
    auto_restart |=> irq); // R6
  AST_IDLE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRACK) && !start_rise |=> !irq && !hold); // R7
endmodule

// File: tb/tb_conv_seq.sv
module tb_conv_seq;
  localparam int H = 2, C = 4, R = 6, F = 4;
  localparam int A = 25;                 // 100 ns at a 4 ns clock
  localparam int L = H + C + R + F;
  localparam int P = L + 1 + A;          // free-running period

  localparam int EV_RISE = 0, EV_COARSE = 1, EV_FINE = 2, EV_LATCH = 3, EV_FALL = 4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] cyc;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic conv_n = 1'b1;
  logic hold, coarse_stb, fine_stb, latch_stb, irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic prev_irq = 1'b0;
  bit done = 1'b0;
  ev_t expq[$];

  conv_seq dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .conv_n(conv_n),
    .hold(hold), .coarse_stb(coarse_stb), .fine_stb(fine_stb),
    .latch_stb(latch_stb), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string req_of(input int k);
    case (k)
      EV_RISE:   return "R2";
      EV_COARSE: return "R3";
      EV_FINE:   return "R3";
      EV_LATCH:  return "R4";
      default:   return "R4";
    endcase
  endfunction

  // Driver side: expected events for a start driven while cyc == m
  task automatic expect_conv(input int m);
    expq.push_back(ev_t'{kind: 3'(EV_RISE),   cyc: 32'(m + 1)});
    expq.push_back(ev_t'{kind: 3'(EV_COARSE), cyc: 32'(m + H + C)});
    expq.push_back(ev_t'{kind: 3'(EV_FINE),   cyc: 32'(m + L)});
    expq.push_back(ev_t'{kind: 3'(EV_LATCH),  cyc: 32'(m + L + 1)});
    expq.push_back(ev_t'{kind: 3'(EV_FALL),   cyc: 32'(m + L + 2)});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Monitor side
  task automatic observe(input int k);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL %s (R5/R1) unexpected event: actual=kind%0d@%0d expected=none", req_of(k), k, cyc);
    end else begin
      e = expq.pop_front();
      if (int'(e.kind) != k || int'(e.cyc) != cyc) begin
        errors++;
        $display("FAIL %s event: actual=kind%0d@%0d expected=kind%0d@%0d",
                 req_of(k), k, cyc, int'(e.kind), int'(e.cyc));
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (irq && !prev_irq) observe(EV_RISE);
      if (coarse_stb)       observe(EV_COARSE);
      if (fine_stb)         observe(EV_FINE);
      if (latch_stb)        observe(EV_LATCH);
      if (!irq && prev_irq) observe(EV_FALL);
      if (hold !== irq) begin
        errors++;
        $display("FAIL R2 hold/irq mismatch: actual=%0b expected=%0b", hold, irq);
      end
    end
    prev_irq <= irq;
  end

  initial begin
    int m;
    tick(3);
    check("R8", int'(irq), 0, "irq in reset");
    check("R8", int'(hold), 0, "hold in reset");
    check("R8", int'(coarse_stb | fine_stb | latch_stb), 0, "strobes in reset");
    rst = 1'b0;
    tick(5);
    check("R7", int'(irq | hold), 0, "idle after reset");

    // Single shot with a short convert pulse; later pulses inside the cycle are ignored
    cs_n = 1'b0;
    tick(3);
    conv_n = 1'b0; m = cyc; expect_conv(m);
    tick(1); conv_n = 1'b1;
    tick(6); conv_n = 1'b0; tick(1); conv_n = 1'b1;       // R5: inside conversion
    while (cyc < m + L + 6) tick(1);
    conv_n = 1'b0; tick(2); conv_n = 1'b1;                // R5: inside acquisition
    while (cyc < m + P + 15) tick(1);
    check("R5", int'(irq), 0, "no retrigger after ignored pulses");
    check("R5", expq.size(), 0, "pending events after single shot");

    // Convert pulse with chip select high starts nothing
    cs_n = 1'b1;
    conv_n = 1'b0; tick(2); conv_n = 1'b1;
    tick(5);
    check("R1", int'(irq), 0, "convert with chip select high");
    // Convert falls first, chip select later triggers
    conv_n = 1'b0; tick(4);
    check("R1", int'(irq), 0, "convert low alone");
    cs_n = 1'b0; m = cyc; expect_conv(m);
    tick(1); cs_n = 1'b1; conv_n = 1'b1;
    while (cyc < m + P + 10) tick(1);
    check("R1", expq.size(), 0, "pending events after later-select start");

    // Continuous mode: three cycles, released inside the third conversion
    cs_n = 1'b0;
    conv_n = 1'b0; m = cyc;
    for (int k = 0; k < 3; k++) expect_conv(m + k * P);
    while (cyc < m + 2 * P + 5) tick(1);
    check("R6", int'(irq), 1, "third cycle running");
    conv_n = 1'b1;
    while (cyc < m + 3 * P + 20) tick(1);
    check("R6", int'(irq), 0, "stopped after release");
    check("R6", expq.size(), 0, "pending events after continuous run");

    // Idle for a while
    tick(100);
    check("R7", int'(hold), 0, "hold stays in track");
    check("R7", int'(irq), 0, "irq stays low");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule